// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block performs the integer execute step for a small 32-bit load/store RISC core. Each beat carries a decoded operation code, the two source register values and the raw 16-bit immediate field of the instruction. The unit forms the arithmetic or logical result, the byte address for a load or store, and a flag that says whether the two register values match. The branch logic uses that flag.

All of this work is combinational. A single output register stage captures it when a beat is presented. A one-cycle valid pulse marks the captured beat, and the stage holds its contents between beats. Register file access, data memory access, multiply and divide, and floating point belong to other blocks.

The reset input clears the unit at once, whenever it is asserted. Its release reaches the output stage only after two clock edges.

Top module: `risc_exec_unit`

## Requirements
- R1: While reset is asserted, and after it is released before any beat arrives, out_valid, out_result, out_addr and out_equal are all zero.
- R2: Code 0 (add), code 1 (subtract, rs minus rt) and code 3 (add-immediate) wrap modulo 2^32 and never trap. Add-immediate sign-extends the 16-bit immediate.
- R3: Code 2 compares rs against rt, and code 4 compares rs against the sign-extended immediate. Both compare as two's-complement values and give 1 when the first operand is smaller, 0 otherwise.
- R4: Code 7 (load-upper) places the immediate in result bits 31:16 and zeros bits 15:0.
- R5: Code 5 (AND-immediate) and code 6 (OR-immediate) zero-extend the immediate. An OR-immediate applied to a load-upper result gives the concatenation of the upper and lower halves.
- R6: out_addr equals rs plus the sign-extended immediate, for every code. Code 8 (memory access) also returns that address on out_result.
- R7: A beat with in_valid high at a rising edge produces out_valid high for exactly the following cycle, with that beat's results. out_valid is low after a cycle without in_valid.
- R8: out_equal is 1 exactly when rs and rt are bit-identical, for every code.
- R9: While in_valid is low, out_result, out_addr and out_equal keep their last captured values, whatever the other inputs do.
- R10: An add with rt equal to zero returns rs unchanged (the move idiom).
- R11: Codes 9 to 15 give a result of zero. out_addr and out_equal still follow R6 and R8 for these codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present on the operand inputs |
| in_op | input | 4 | Decoded operation code |
| in_rs | input | 32 | First register operand / base address |
| in_rt | input | 32 | Second register operand |
| in_imm | input | 16 | Raw immediate field |
| out_valid | output | 1 | One-cycle pulse marking a captured beat |
| out_result | output | 32 | Operation result |
| out_addr | output | 32 | Effective byte address |
| out_equal | output | 1 | rs equals rt |

## Verification
Every result, address and equality flag crosses exactly one register, so each is due on the cycle that follows the edge at which in_valid was sampled high. The bench drives a beat on a falling edge and lets one rising edge capture it. It then reads all outputs on the next falling edge, and reads again one cycle later to see out_valid drop. The hold checks change the operand inputs with in_valid low for two edges, and compare the outputs with the last captured beat.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_ADDI = 4'd3,
    OP_SLTI = 4'd4,
    OP_ANDI = 4'd5,
    OP_ORI  = 4'd6,
    OP_LUI  = 4'd7,
    OP_MEM  = 4'd8
  } exu_op_e;

endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] imm_sext,
  output logic [DATA_W-1:0] imm_zext,
  output logic [DATA_W-1:0] imm_upper
);
  localparam int FILL_W = DATA_W - IMM_W;

  always_comb begin
    imm_sext  = {{FILL_W{imm[IMM_W-1]}}, imm};
    imm_zext  = {{FILL_W{1'b0}}, imm};
    imm_upper = {imm, {FILL_W{1'b0}}};
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm_sext,
  input  logic [DATA_W-1:0] imm_zext,
  input  logic [DATA_W-1:0] imm_upper,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] addr,
  output logic              equal
);
  logic [DATA_W-1:0] sum_rr, diff_rr, sum_ri;
  logic              lt_rr, lt_ri;

  always_comb begin
    sum_rr  = opa + opb;
    diff_rr = opa - opb;
    sum_ri  = opa + imm_sext;
    lt_rr   = $signed(opa) < $signed(opb);
    lt_ri   = $signed(opa) < $signed(imm_sext);
    addr    = sum_ri;
    equal   = (opa == opb);
  end

  always_comb begin
    result = '0;
    case (op)
      OP_ADD:  result = sum_rr;
      OP_SUB:  result = diff_rr;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, lt_rr};
      OP_ADDI: result = sum_ri;
      OP_SLTI: result = {{(DATA_W-1){1'b0}}, lt_ri};
      OP_ANDI: result = opa & imm_zext;
      OP_ORI:  result = opa | imm_zext;
      OP_LUI:  result = imm_upper;
      OP_MEM:  result = sum_ri;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/exu_out_reg.sv
module exu_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_result,
  input  logic [DATA_W-1:0] d_addr,
  input  logic              d_equal,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_result,
  output logic [DATA_W-1:0] q_addr,
  output logic              q_equal
);
  logic              valid_nx, equal_nx;
  logic [DATA_W-1:0] result_nx, addr_nx;

  always_comb begin
    valid_nx  = load;
    result_nx = q_result;
    addr_nx   = q_addr;
    equal_nx  = q_equal;
    if (load) begin
      result_nx = d_result;
      addr_nx   = d_addr;
      equal_nx  = d_equal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_addr   <= '0;
      q_equal  <= 1'b0;
    end else begin
      q_valid  <= valid_nx;
      q_result <= result_nx;
      q_addr   <= addr_nx;
      q_equal  <= equal_nx;
    end
  end
endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [DATA_W-1:0] out_addr,
  output logic              out_equal
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
  logic [DATA_W-1:0] alu_result, alu_addr;
  logic              alu_equal;
  logic              cap_en;

  exu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm      (in_imm),
    .imm_sext (imm_sext),
    .imm_zext (imm_zext),
    .imm_upper(imm_upper)
  );

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (in_op),
    .opa      (in_rs),
    .opb      (in_rt),
    .imm_sext (imm_sext),
    .imm_zext (imm_zext),
    .imm_upper(imm_upper),
    .result   (alu_result),
    .addr     (alu_addr),
    .equal    (alu_equal)
  );

  assign cap_en = in_valid;

  exu_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load    (cap_en),
    .d_result(alu_result),
    .d_addr  (alu_addr),
    .d_equal (alu_equal),
    .q_valid (out_valid),
    .q_result(out_result),
    .q_addr  (out_addr),
    .q_equal (out_equal)
  );
endmodule

// File: rtl/risc_exec_unit_chk.sv
module risc_exec_unit_chk
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic [DATA_W-1:0] in_rs,
  input logic [DATA_W-1:0] in_rt,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [DATA_W-1:0] out_addr,
  input logic              out_equal
);
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  a_r3_slt_boolean: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (in_op == OP_SLT || in_op == OP_SLTI))
      |=> (out_result[DATA_W-1:1] == '0));

  a_r4_lui_layout: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op == OP_LUI)
      |=> (out_result[IMM_W-1:0] == '0 &&
           out_result[DATA_W-1:DATA_W-IMM_W] == $past(in_imm)));

  a_r6_address: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (out_addr == $past(in_rs) +
      {{(DATA_W-IMM_W){$past(in_imm[IMM_W-1])}}, $past(in_imm)}));

  a_r8_equal_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (out_equal == ($past(in_rs) == $past(in_rt))));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_result) && $stable(out_addr) && $stable(out_equal)));
endmodule

bind risc_exec_unit risc_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_rs     (in_rs),
  .in_rt     (in_rt),
  .in_imm    (in_imm),
  .out_valid (out_valid),
  .out_result(out_result),
  .out_addr  (out_addr),
  .out_equal (out_equal)
);

// File: tb/tb_risc_exec_unit.sv
module tb_risc_exec_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_rs, in_rt;
  logic [15:0] in_imm;
  logic        out_valid;
  logic [31:0] out_result, out_addr;
  logic        out_equal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  risc_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .out_valid(out_valid), .out_result(out_result),
    .out_addr(out_addr), .out_equal(out_equal)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One beat: drive on a falling edge, capture on the rising edge, read on the next falling edge.
  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] rs,
                        input logic [31:0] rt, input logic [15:0] imm,
                        input logic [31:0] exp_res, input bit chk_addr,
                        input logic [31:0] exp_addr, input logic exp_eq);
    @(negedge clk);
    in_valid = 1; in_op = op; in_rs = rs; in_rt = rt; in_imm = imm;
    @(negedge clk);
    in_valid = 0;
    check({req, " R7 valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, out_result, exp_res);
    if (chk_addr) check({req, " R6 addr"}, out_addr, exp_addr);
    check({req, " R8 equal"}, {31'd0, out_equal}, {31'd0, exp_eq});
    @(negedge clk);
    check({req, " R7 valid drop"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", out_result, 32'd0);
    check("R1 addr", out_addr, 32'd0);
    check("R1 equal", {31'd0, out_equal}, 32'd0);
  endtask

  task automatic t_arith();
    run_op("R2 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd2, 16'd0, 32'd1, 0, 0, 0);
    run_op("R2 sub", 4'd1, 32'd5, 32'd7, 16'd0, 32'hFFFF_FFFE, 0, 0, 0);
    run_op("R2 addi neg", 4'd3, 32'd10, 32'd0, 16'hFFFE, 32'd8, 0, 0, 0);
  endtask

  task automatic t_slt();
    run_op("R3 slt neg<pos", 4'd2, 32'hFFFF_FFFF, 32'd1, 16'd0, 32'd1, 0, 0, 0);
    run_op("R3 slt pos<neg", 4'd2, 32'd1, 32'hFFFF_FFFF, 16'd0, 32'd0, 0, 0, 0);
    run_op("R3 slti", 4'd4, 32'hFFFF_FFFB, 32'd0, 16'hFFFF, 32'd1, 0, 0, 0);
  endtask

  task automatic t_logic_const();
    run_op("R4 lui", 4'd7, 32'h1111_1111, 32'd0, 16'hDEAD, 32'hDEAD_0000, 0, 0, 0);
    run_op("R5 andi zext", 4'd5, 32'hFFFF_FFFF, 32'd0, 16'h8001, 32'h0000_8001, 0, 0, 0);
    run_op("R5 ori const", 4'd6, 32'hDEAD_0000, 32'd0, 16'hBEEF, 32'hDEAD_BEEF, 0, 0, 0);
  endtask

  task automatic t_mem();
    run_op("R6 mem neg off", 4'd8, 32'h0000_1000, 32'd0, 16'hFFFC, 32'h0000_0FFC, 1, 32'h0000_0FFC, 0);
    run_op("R6 addr on add", 4'd0, 32'h0000_1000, 32'd3, 16'h0020, 32'h0000_1003, 1, 32'h0000_1020, 0);
  endtask

  task automatic t_equal_move();
    run_op("R8 equal", 4'd1, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 16'd0, 32'd0, 0, 0, 1);
    run_op("R10 move", 4'd0, 32'hCAFE_F00D, 32'd0, 16'd0, 32'hCAFE_F00D, 0, 0, 0);
    run_op("R11 undefined", 4'd12, 32'd9, 32'd9, 16'd4, 32'd0, 1, 32'd13, 1);
  endtask

  task automatic t_hold();
    run_op("R9 setup", 4'd0, 32'd100, 32'd23, 16'd1, 32'd123, 1, 32'd101, 0);
    @(negedge clk);
    in_op = 4'd1; in_rs = 32'd7; in_rt = 32'd7; in_imm = 16'h0F0F;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold valid", {31'd0, out_valid}, 32'd0);
    check("R9 hold result", out_result, 32'd123);
    check("R9 hold addr", out_addr, 32'd101);
    check("R9 hold equal", {31'd0, out_equal}, 32'd0);
  endtask

  initial begin
    in_valid = 0; in_op = 0; in_rs = 0; in_rt = 0; in_imm = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_arith();
    t_slt();
    t_logic_const();
    t_mem();
    t_equal_move();
    t_hold();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule